// File: doc/BRIEF.md
# Four-Way Instruction Fetch Cache

This block is a read-only instruction cache placed between a pipeline fetch stage and a word-wide backing memory. It holds 64 sets of four ways, and each line is eight 32-bit words (32 bytes). A fetch request probes every way of the indexed set at once. On a hit, the instruction word goes back to the fetch stage in the same cycle.

On a miss, the cache raises a stall toward the fetch stage and first waits a fixed number of cycles. It then loads the whole line through a simple request/valid refill port, one word at a time. While the stall is high, the fetch stage is expected to issue bubbles and to retry the same address afterwards. Once the line is complete, the retried fetch hits.

Victim selection uses a small saturating age counter per line. The counters change only when a line is allocated, never on a hit. When a full set needs a victim, ties go to the highest way number.

Top module: `fetch_icache`

## Requirements
- R1: After reset, every line is invalid and every age counter is zero, so the first fetch to any address misses. While reset is held, `fetch_ready`, `fetch_stall` and `mem_req` are all 0.
- R2: Address fields are as follows. The set is selected by address bits [10:5]. The tag is bits [19:11]. The word within the line is bits [4:2]. Bits [31:20] and [1:0] play no part in the lookup. On a hit, `fetch_ready` is 1 in the same cycle as the request, and `fetch_data` is the stored word.
- R3: When a set with at least one invalid way misses, the lowest-numbered invalid way is allocated and its age is set to 0. Every other way in that set ages by one, saturating at 3.
- R4: A hit leaves every age counter unchanged.
- R5: When all four ways of a set are valid, a miss ages every way by two, saturating at 3. The victim is the highest-numbered way holding the largest resulting age, and its age becomes 0.
- R6: A miss raises `fetch_stall` in the miss cycle and holds it through a wait of 41 cycles and the whole refill. With a memory that answers every request at once, the stall lasts exactly 50 cycles. `fetch_ready` stays 0 while `fetch_stall` is 1.
- R7: The refill reads eight words in increasing order. Each word address is the request address with bits [4:0] replaced by the word number times 4. `mem_req` stays high and `mem_addr` stays fixed until `mem_valid` accepts the word.
- R8: The allocated way becomes valid only after its eighth word is written. The fetch retried in the first cycle after the stall hits.
- R9: When `fetch_req` is 0 and no refill is running, the block does nothing: no stall, no memory request, and no change to cached contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_req | input | 1 | Fetch stage requests an instruction |
| fetch_addr | input | 32 | Byte address of the instruction |
| fetch_ready | output | 1 | Hit: `fetch_data` is valid this cycle |
| fetch_data | output | 32 | Instruction word |
| fetch_stall | output | 1 | Miss in progress; fetch issues bubbles |
| mem_req | output | 1 | Refill word request |
| mem_addr | output | 32 | Word-aligned refill address |
| mem_rdata | input | 32 | Refill word from memory |
| mem_valid | input | 1 | `mem_rdata` answers the current request |

## Verification
The miss decision and the replacement update fall in the same cycle. In that one cycle, the lookup reads a set's tags and the victim choice rewrites the same set's ages and tag. The test provokes this by filling one set with five distinct tags and then alternating hits and misses to that set, so that every miss acts on ages left by the previous allocation. Each outcome is judged against a behavioural model that predicts, cycle by cycle, which later fetch hits, which misses, and the exact refill addresses. Independently worked hit/miss expectations for the eviction order are checked by name as well.

// File: rtl/fetch_icache_pkg.sv
package fetch_icache_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_WAIT = 2'd1,
    FS_FILL = 2'd2
  } fill_state_e;
endpackage

// File: rtl/icache_tag_match.sv
module icache_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 9,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           probe_tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic [WAYS-1:0]            match_vec
);
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match_vec[g] = way_valid[g] && (way_tag[g] == probe_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (match_vec[i]) hit_way = WAY_W'(i);
    end
  end

  assign hit = |match_vec;
endmodule

// File: rtl/icache_age_policy.sv
module icache_age_policy #(
  parameter int WAYS    = 4,
  parameter int AGE_MAX = 3,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int AGE_W  = $clog2(AGE_MAX + 1)
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][AGE_W-1:0] age_cur,
  output logic [WAY_W-1:0]           victim,
  output logic [WAYS-1:0][AGE_W-1:0] age_next
);
  logic [WAYS-1:0][AGE_W-1:0] bump_one;
  logic [WAYS-1:0][AGE_W-1:0] bump_two;
  logic                       any_free;
  logic [WAY_W-1:0]           free_way;
  logic [WAY_W-1:0]           oldest_way;
  logic [AGE_W-1:0]           oldest_age;

  for (genvar g = 0; g < WAYS; g++) begin : g_sat
    assign bump_one[g] = (age_cur[g] >= AGE_W'(AGE_MAX)) ? AGE_W'(AGE_MAX) : age_cur[g] + 1'b1;
    assign bump_two[g] = (bump_one[g] >= AGE_W'(AGE_MAX)) ? AGE_W'(AGE_MAX) : bump_one[g] + 1'b1;
  end

  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!way_valid[i]) begin
        any_free = 1'b1;
        free_way = WAY_W'(i);
      end
    end
    oldest_age = '0;
    oldest_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (bump_two[i] >= oldest_age) begin
        oldest_age = bump_two[i];
        oldest_way = WAY_W'(i);
      end
    end
    victim = any_free ? free_way : oldest_way;
    for (int i = 0; i < WAYS; i++) begin
      if (WAY_W'(i) == victim) age_next[i] = '0;
      else                     age_next[i] = any_free ? bump_one[i] : bump_two[i];
    end
  end
endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl
  import fetch_icache_pkg::*;
#(
  parameter int WAIT_CYCLES = 41,
  parameter int LINE_WORDS  = 8,
  localparam int CNT_W  = $clog2(WAIT_CYCLES + 1),
  localparam int WORD_W = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mem_valid,
  output logic              busy,
  output logic              mem_req,
  output logic [WORD_W-1:0] word_idx,
  output logic              fill_done
);
  fill_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] idx_q, idx_d;
  logic              wait_over;
  logic              word_take;

  assign wait_over = (state_q == FS_WAIT) && (cnt_q == CNT_W'(WAIT_CYCLES - 1));
  assign word_take = (state_q == FS_FILL) && mem_valid;
  assign fill_done = word_take && (idx_q == WORD_W'(LINE_WORDS - 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    case (state_q)
      FS_IDLE: if (start) begin
        state_d = FS_WAIT;
        cnt_d   = '0;
      end
      FS_WAIT: if (wait_over) begin
        state_d = FS_FILL;
        idx_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      FS_FILL: if (word_take) begin
        idx_d = idx_q + 1'b1;
        if (fill_done) state_d = FS_IDLE;
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
    end
  end

  assign busy     = (state_q != FS_IDLE);
  assign mem_req  = (state_q == FS_FILL);
  assign word_idx = idx_q;

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_WAIT) |-> (cnt_q < CNT_W'(WAIT_CYCLES))); // R6
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid && !fill_done) |=> (mem_req && idx_q == $past(idx_q) + 1'b1)); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(idx_q))); // R7
endmodule

// File: rtl/fetch_icache.sv
module fetch_icache #(
  parameter int WAYS        = 4,
  parameter int SETS        = 64,
  parameter int LINE_WORDS  = 8,
  parameter int TAG_HI      = 19,
  parameter int WAIT_CYCLES = 41,
  parameter int AGE_MAX     = 3,
  localparam int DATA_W = 32,
  localparam int ADDR_W = 32,
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int WORD_W = $clog2(LINE_WORDS),
  localparam int OFF_W  = BYTE_W + WORD_W,
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_LO = OFF_W + IDX_W,
  localparam int TAG_W  = TAG_HI - TAG_LO + 1,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int AGE_W  = $clog2(AGE_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic [DATA_W-1:0] fetch_data,
  output logic              fetch_stall,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_valid
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [SETS-1:0][WAYS-1:0]            valid_q, valid_d;
  logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] age_q, age_d;
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [DATA_W-1:0] data_q [SETS][WAYS][LINE_WORDS];

  logic [IDX_W-1:0]  req_set;
  logic [TAG_W-1:0]  req_tag;
  logic [WORD_W-1:0] req_word;
  logic              unused_byte_bits;

  assign req_set          = fetch_addr[TAG_LO-1:OFF_W];
  assign req_tag          = fetch_addr[TAG_HI:TAG_LO];
  assign req_word         = fetch_addr[OFF_W-1:BYTE_W];
  assign unused_byte_bits = ^fetch_addr[BYTE_W-1:0];

  logic [WAYS-1:0][TAG_W-1:0] set_tag;
  always_comb begin
    for (int w = 0; w < WAYS; w++) set_tag[w] = tag_q[req_set][w];
  end

  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAYS-1:0]  match_vec;

  icache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .way_valid (valid_q[req_set]),
    .way_tag   (set_tag),
    .probe_tag (req_tag),
    .hit       (hit),
    .hit_way   (hit_way),
    .match_vec (match_vec)
  );

  logic [WAY_W-1:0]            victim;
  logic [WAYS-1:0][AGE_W-1:0]  age_next;

  icache_age_policy #(.WAYS(WAYS), .AGE_MAX(AGE_MAX)) u_age (
    .way_valid (valid_q[req_set]),
    .age_cur   (age_q[req_set]),
    .victim    (victim),
    .age_next  (age_next)
  );

  logic              busy;
  logic              miss_take;
  logic              fill_done;
  logic [WORD_W-1:0] word_idx;

  assign miss_take = fetch_req && !hit && !busy;

  icache_fill_ctrl #(.WAIT_CYCLES(WAIT_CYCLES), .LINE_WORDS(LINE_WORDS)) u_fill (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (miss_take),
    .mem_valid (mem_valid),
    .busy      (busy),
    .mem_req   (mem_req),
    .word_idx  (word_idx),
    .fill_done (fill_done)
  );

  logic [IDX_W-1:0]        fill_set_q;
  logic [WAY_W-1:0]        fill_way_q;
  logic [ADDR_W-OFF_W-1:0] fill_line_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      fill_set_q  <= '0;
      fill_way_q  <= '0;
      fill_line_q <= '0;
    end else if (miss_take) begin
      fill_set_q  <= req_set;
      fill_way_q  <= victim;
      fill_line_q <= fetch_addr[ADDR_W-1:OFF_W];
    end
  end

  always_comb begin
    valid_d = valid_q;
    age_d   = age_q;
    if (miss_take) begin
      age_d[req_set]           = age_next;
      valid_d[req_set][victim] = 1'b0;
    end
    if (fill_done) valid_d[fill_set_q][fill_way_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= '0;
      age_q   <= '0;
    end else begin
      valid_q <= valid_d;
      age_q   <= age_d;
    end
  end

  always_ff @(posedge clk) begin
    if (miss_take) tag_q[req_set][victim] <= req_tag;
    if (mem_req && mem_valid) data_q[fill_set_q][fill_way_q][word_idx] <= mem_rdata;
  end

  assign fetch_ready = fetch_req && hit && !busy;
  assign fetch_stall = busy || miss_take;
  assign fetch_data  = data_q[req_set][hit_way][req_word];
  assign mem_addr    = {fill_line_q, word_idx, {BYTE_W{1'b0}}};

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_int_n)
    fetch_req |-> $onehot0(match_vec)); // R2
  AST_HIT_KEEPS_AGE: assert property (@(posedge clk) disable iff (!rst_int_n)
    fetch_ready |=> $stable(age_q)); // R4
  AST_VICTIM_YOUNG: assert property (@(posedge clk) disable iff (!rst_int_n)
    miss_take |=> (age_q[fill_set_q][fill_way_q] == '0)); // R5
  AST_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_int_n)
    fetch_stall |-> !fetch_ready); // R6
  AST_LINE_HIDDEN: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req |-> !valid_q[fill_set_q][fill_way_q]); // R8
  AST_LINE_SHOWN: assert property (@(posedge clk) disable iff (!rst_int_n)
    fill_done |=> valid_q[fill_set_q][fill_way_q]); // R8
endmodule

// File: tb/fetch_icache_test.sv
module fetch_icache_test;
  logic        clk;
  logic        rst_n;
  logic        req;
  logic [31:0] addr;
  logic        grant;
  logic        ready, stall, mem_req;
  logic [31:0] data, mem_addr, mem_rdata;
  logic        mem_valid;

  int checks = 0;
  int errors = 0;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h13572468;
  endfunction

  assign mem_valid = mem_req & grant;
  assign mem_rdata = memf(mem_addr);

  fetch_icache uut (
    .clk(clk), .rst_n(rst_n), .fetch_req(req), .fetch_addr(addr),
    .fetch_ready(ready), .fetch_data(data), .fetch_stall(stall),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_valid(mem_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference state
  bit          mv [64][4];
  int          ma [64][4];
  int          mt [64][4];
  logic [31:0] mb [64][4];
  bit          mbusy = 0;
  int          wleft = 0, fleft = 0, fs = 0, fw = 0;
  logic [31:0] fbase = 0;
  bit          gmode = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic model_miss(input int s, input int t, input logic [31:0] a);
    int free, best, vic;
    free = -1;
    for (int k = 0; k < 4; k++) if (!mv[s][k] && free < 0) free = k;
    if (free >= 0) begin
      for (int k = 0; k < 4; k++) ma[s][k] = (k == free) ? 0 : ((ma[s][k] + 1 > 3) ? 3 : ma[s][k] + 1);
      vic = free;
    end else begin
      best = -1; vic = 0;
      for (int k = 0; k < 4; k++) begin
        ma[s][k] = (ma[s][k] + 2 > 3) ? 3 : ma[s][k] + 2;
        if (ma[s][k] >= best) begin best = ma[s][k]; vic = k; end
      end
      ma[s][vic] = 0;
    end
    mv[s][vic] = 0; mt[s][vic] = t; mb[s][vic] = a & ~32'h1F;
    fs = s; fw = vic; fbase = a & ~32'h1F;
    mbusy = 1; wleft = 41; fleft = 8;
  endtask

  task automatic step(input logic r, input logic [31:0] a);
    bit er, es, em;
    logic [31:0] ed, ema;
    int s, t, hw;
    @(posedge clk); #1;
    req = r; addr = a;
    grant = gmode ? ~grant : 1'b1;
    @(negedge clk);
    er = 0; es = 0; em = 0; ed = 0; ema = 0;
    if (!mbusy) begin
      if (r) begin
        s = int'((a >> 5) & 32'd63); t = int'((a >> 11) & 32'd511); hw = -1;
        for (int k = 0; k < 4; k++) if (mv[s][k] && mt[s][k] == t) hw = k;
        if (hw >= 0) begin er = 1; ed = memf(mb[s][hw] + (a & 32'h1C)); end
        else begin es = 1; model_miss(s, t, a); end
      end
    end else begin
      es = 1;
      if (wleft > 0) wleft--;
      else begin
        em = 1; ema = fbase + 32'(4 * (8 - fleft));
        if (grant) begin
          fleft--;
          if (fleft == 0) begin mv[fs][fw] = 1; mbusy = 0; end
        end
      end
    end
    chk(ready === er, "R2", "fetch_ready", 32'(ready), 32'(er));
    chk(stall === es, "R6", "fetch_stall", 32'(stall), 32'(es));
    chk(mem_req === em, "R7", "mem_req", 32'(mem_req), 32'(em));
    if (er) chk(data === ed, "R2", "fetch_data", data, ed);
    if (em) chk(mem_addr === ema, "R7", "mem_addr", mem_addr, ema);
  endtask

  task automatic fetch(input logic [31:0] a, output int stalls, output bit first_hit,
                       output logic [31:0] got);
    stalls = 0; first_hit = 0; got = 0;
    for (int n = 0; n < 400; n++) begin
      step(1'b1, a);
      if (ready === 1'b1) begin
        got = data;
        first_hit = (n == 0);
        break;
      end
      stalls++;
    end
  endtask

  task automatic expect_first(input logic [31:0] a, input bit exp_hit, input string rq);
    int st; bit fh; logic [31:0] g;
    fetch(a, st, fh, g);
    chk(fh == exp_hit, rq, "first-cycle hit", 32'(fh), 32'(exp_hit));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam logic [31:0] A = 32'h0000_0860, B = 32'h0000_1060, C = 32'h0000_1860;
  localparam logic [31:0] D = 32'h0000_2060, E = 32'h0000_2860;

  initial begin
    int st; bit fh; logic [31:0] g;
    for (int s = 0; s < 64; s++) for (int k = 0; k < 4; k++) begin
      mv[s][k] = 0; ma[s][k] = 0; mt[s][k] = 0; mb[s][k] = 0;
    end
    rst_n = 1'b0; req = 1'b0; addr = '0; grant = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(ready === 1'b0 && stall === 1'b0 && mem_req === 1'b0, "R1", "outputs in reset",
          {29'd0, ready, stall, mem_req}, 32'd0);
    end
    rst_n = 1'b1;
    repeat (4) step(1'b0, 32'h0);

    // R1 first fetch misses; R6 stall length; R8 retry hits right after
    fetch(A + 32'h8, st, fh, g);
    chk(fh == 1'b0, "R1", "first fetch hit", 32'(fh), 32'd0);
    chk(st == 50, "R6", "stall cycles", 32'(st), 32'd50);
    chk(g === memf(A + 32'h8), "R8", "retry data", g, memf(A + 32'h8));

    // R2 other word of same line hits at once
    fetch(A + 32'h1C, st, fh, g);
    chk(fh == 1'b1, "R2", "same-line hit", 32'(fh), 32'd1);
    chk(g === memf(A + 32'h1C), "R2", "word select", g, memf(A + 32'h1C));

    // R3 fill remaining ways in order, then R5 eviction order
    fetch(B, st, fh, g); fetch(C, st, fh, g); fetch(D, st, fh, g);
    fetch(E, st, fh, g);                 // full set: ages 3,2,1,0 -> way 2 (C) evicted
    expect_first(A, 1'b1, "R3");
    expect_first(B, 1'b1, "R3");
    expect_first(D, 1'b1, "R5");
    expect_first(E, 1'b1, "R4");
    expect_first(C, 1'b0, "R5");         // C returns, evicts D (way 3)
    expect_first(E, 1'b1, "R4");         // hits do not age, E survives
    expect_first(D, 1'b0, "R5");         // D returns, evicts E (way 2)
    expect_first(E, 1'b0, "R5");

    // R2 upper and byte bits ignored
    fetch(A | 32'hABC0_0007, st, fh, g);
    chk(fh == 1'b1, "R2", "alias hit", 32'(fh), 32'd1);
    chk(g === memf(A + 32'h4), "R2", "alias data", g, memf(A + 32'h4));

    // R9 idle cycles change nothing
    repeat (6) step(1'b0, 32'hFFFF_FFFF);
    expect_first(A, 1'b1, "R9");

    // R7 refill with memory that answers every other cycle
    gmode = 1'b1;
    fetch(32'h7FF0_1540, st, fh, g);
    chk(g === memf(32'h7FF0_1540), "R7", "gapped refill data", g, memf(32'h7FF0_1540));
    gmode = 1'b0;
    expect_first(32'h7FF0_155C, 1'b1, "R7");

    // neighbouring set is independent
    fetch(A + 32'h20, st, fh, g);
    chk(fh == 1'b0, "R3", "new set miss", 32'(fh), 32'd0);
    expect_first(A, 1'b1, "R4");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule